// File: doc/BRIEF.md
# Serial/Parallel FIFO Entry Stage

This block is the front end of a 4-bit-wide first-in first-out buffer. It gathers one word at a time, either as four bits presented together under a load strobe or as a bit-serial stream clocked by a slow serial clock. When a word is complete it drops its active-low full flag and offers the word to the downstream stack. The stack accepts it through a one-cycle write strobe, which is raised only while the stack reports a free top location and the transfer request is held low. After the transfer the register clears itself and waits for the next word.

Word completion is detected without a counter. A marker bit is loaded into the top data position when the register clears, and it moves one place down with every serial shift. When the marker leaves the bottom data bit and lands in the completion flag, the fourth bit has arrived. Each word is written only once, however long the transfer request stays low. Clearing after a write is held back while the parallel load strobe is high. It is also held back for a chained slave device until its chain-enable input goes low. Whether the device acts as master or slave is captured during reset. Wiring the full flag back to the transfer request gives fully automatic entry.

All inputs, the serial clock included, are sampled on one system clock. The serial clock passes through a synchronizer and its falling edge is detected in that clock domain. Reset is synchronous and active-low.

Top module: `fifo_entry_stage`

## Requirements
- R1: While rstN is low at a clock edge, the register clears: after that edge fullN reads 1 (1 = empty) and stackWr reads 0.
- R2: A clock edge with parLoad high copies parIn into the register and sets the completion flag. stackData then equals parIn and fullN reads 0.
- R3: With chainEnN and parLoad low and the register empty, each falling edge of serClk shifts serIn in. The shift takes effect on the third system clock edge after the fall. fullN drops only after the fourth such edge. The first bit received ends up in stackData bit 0 and the fourth bit in bit 3.
- R4: serClk falling edges change nothing while the word is complete (fullN low) or while chainEnN is high.
- R5: stackWr is high, combinationally, in any cycle where fullN is low, xferReqN is low, stackReady is high and the word has not yet been written. In that cycle stackData carries the word.
- R6: While stackReady is low, no write occurs and the held word and fullN stay unchanged.
- R7: stackWr is high for exactly one cycle per word, even while xferReqN stays low.
- R8: In master mode with parLoad low, fullN returns to 1 two cycles after the cycle in which stackWr was high. It is still 0 in the cycle in between.
- R9: While parLoad stays high after a write, the register is not cleared and fullN stays 0. fullN reads 1 one cycle after parLoad is first sampled low.
- R10: The device is a master if chainEnN was low during reset and a slave otherwise. A slave clears after a write only in a cycle where chainEnN is low; fullN reads 1 one cycle after that.
- R11: When xferReqN is tied to fullN and stackReady is high, every completed serial word is written exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| parIn | input | WIDTH | Parallel word input |
| parLoad | input | 1 | Parallel load strobe, active high |
| serIn | input | 1 | Serial data bit |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| chainEnN | input | 1 | Active-low serial enable and chain-enable; low during reset selects master |
| xferReqN | input | 1 | Active-low transfer request |
| stackReady | input | 1 | High when the stack top location is free |
| stackWr | output | 1 | One-cycle write strobe to the stack |
| stackData | output | WIDTH | Word offered to the stack |
| fullN | output | 1 | Active-low word-complete flag (1 = empty) |

## Verification
Two events can fall in the same cycle: the acceptance of a stack write and a parallel load strobe that is still high. The bench raises parLoad with a standing request and a ready stack, then holds it for several cycles. It judges that exactly one write occurs, that fullN stays low for the whole hold, and that fullN rises exactly one cycle after parLoad falls. The second pair is a serial clock edge that arrives while a word is already complete. For that case the bench checks that the held word and the full flag are unchanged.

// File: rtl/fifo_entry_pkg.sv
package fifo_entry_pkg;

  // strobes from control to datapath; at most one acts per cycle, initReg wins
  typedef struct packed {
    logic initReg;
    logic loadPar;
    logic shiftSer;
  } entryStrobes_t;

endpackage

// File: rtl/serial_edge_sync.sv
module serial_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serIn,
  output logic fallSeen,
  output logic bitSeen
);

  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] clkPipe;
  logic [LAST:0] datPipe;

  // data travels beside the clock so the bit seen with the edge is the one
  // present when the serial clock fell
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPipe <= '0;
      datPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[LAST-1:0], serClk};
      datPipe <= {datPipe[LAST-1:0], serIn};
    end
  end

  assign fallSeen = clkPipe[LAST] & ~clkPipe[LAST-1];
  assign bitSeen  = datPipe[LAST-1];

endmodule

// File: rtl/entry_datapath.sv
module entry_datapath
  import fifo_entry_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  entryStrobes_t    strobes,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serBit,
  output logic [WIDTH-1:0] wordBits,
  output logic             wordFull
);

  logic [WIDTH-1:0] bitsQ;
  logic [WIDTH-1:0] bitsD;
  logic             fullQ;
  logic             fullD;

  // one slice per bit: the top slice takes the serial bit and the marker
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    localparam logic InitVal = (i == WIDTH - 1);
    logic shiftSrc;
    if (i == WIDTH - 1) begin : g_top
      assign shiftSrc = serBit;
    end else begin : g_inner
      assign shiftSrc = bitsQ[i+1];
    end
    assign bitsD[i] = strobes.initReg  ? InitVal  :
                      strobes.loadPar  ? parIn[i] :
                      strobes.shiftSer ? shiftSrc : bitsQ[i];
  end

  // completion flag: the marker arrives here from bit 0
  assign fullD = strobes.initReg  ? 1'b0     :
                 strobes.loadPar  ? 1'b1     :
                 strobes.shiftSer ? bitsQ[0] : fullQ;

  always_ff @(posedge clk) begin
    bitsQ <= bitsD;
    fullQ <= fullD;
  end

  assign wordBits = bitsQ;
  assign wordFull = fullQ;

endmodule

// File: rtl/entry_control.sv
module entry_control
  import fifo_entry_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          parLoad,
  input  logic          chainEnN,
  input  logic          xferReqN,
  input  logic          stackReady,
  input  logic          serFall,
  input  logic          wordFull,
  output entryStrobes_t strobes,
  output logic          stackWr
);

  logic reqDoneQ;   // word already handed to the stack
  logic masterQ;    // captured in reset: chain enable was low
  logic pendingInit;

  // clearing waits for load low and for mastership or the chain enable
  assign pendingInit = reqDoneQ & ~parLoad & (masterQ | ~chainEnN);

  assign stackWr = rstN & wordFull & ~xferReqN & ~reqDoneQ & stackReady;

  always_comb begin
    strobes          = '0;
    strobes.initReg  = ~rstN | pendingInit;
    strobes.loadPar  = rstN & parLoad;
    strobes.shiftSer = rstN & serFall & ~wordFull & ~chainEnN & ~parLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqDoneQ <= 1'b0;
      masterQ  <= ~chainEnN;
    end else if (pendingInit) begin
      reqDoneQ <= 1'b0;
    end else if (stackWr) begin
      reqDoneQ <= 1'b1;
    end
  end

endmodule

// File: rtl/fifo_entry_stage.sv
module fifo_entry_stage
  import fifo_entry_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             parLoad,
  input  logic             serIn,
  input  logic             serClk,
  input  logic             chainEnN,
  input  logic             xferReqN,
  input  logic             stackReady,
  output logic             stackWr,
  output logic [WIDTH-1:0] stackData,
  output logic             fullN
);

  entryStrobes_t strobes;
  logic          serFall;
  logic          serBit;
  logic          wordFull;

  serial_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .serClk   (serClk),
    .serIn    (serIn),
    .fallSeen (serFall),
    .bitSeen  (serBit)
  );

  entry_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .parLoad    (parLoad),
    .chainEnN   (chainEnN),
    .xferReqN   (xferReqN),
    .stackReady (stackReady),
    .serFall    (serFall),
    .wordFull   (wordFull),
    .strobes    (strobes),
    .stackWr    (stackWr)
  );

  entry_datapath #(.WIDTH(WIDTH)) u_data (
    .clk      (clk),
    .strobes  (strobes),
    .parIn    (parIn),
    .serBit   (serBit),
    .wordBits (stackData),
    .wordFull (wordFull)
  );

  assign fullN = ~wordFull;

endmodule

// File: rtl/fifo_entry_stage_chk.sv
module fifo_entry_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             parLoad,
  input logic             xferReqN,
  input logic             stackReady,
  input logic             stackWr,
  input logic [WIDTH-1:0] stackData,
  input logic             fullN
);

  logic rstHeldQ;
  always_ff @(posedge clk) rstHeldQ <= !rstN;

  always @(negedge clk) begin
    if (rstHeldQ) begin
      AST_RESET_EMPTY: assert (fullN && !stackWr); // R1
    end
  end

  AST_LOAD_FULLS: assert property (@(posedge clk) disable iff (!rstN)
    parLoad |=> !fullN); // R2

  AST_HELD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (!fullN && $past(!fullN) && !$past(parLoad)) |-> $stable(stackData)); // R4

  AST_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    stackWr |-> (stackReady && !fullN && !xferReqN)); // R6

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stackWr |=> !stackWr); // R7

endmodule

bind fifo_entry_stage fifo_entry_stage_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_fifo_entry_stage.sv
module tb_fifo_entry_stage;

  logic       clk = 1'b0;
  logic       rstN, parLoad, serIn, serClk, chainEnN, reqDrv, stackReady;
  logic       autoMode;
  logic [3:0] parIn;
  logic       xferReqN, stackWr, fullN;
  logic [3:0] stackData;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [3:0] lastWord = '0;

  always #10 clk = ~clk;

  assign xferReqN = autoMode ? fullN : reqDrv;

  fifo_entry_stage dut (
    .clk(clk), .rstN(rstN), .parIn(parIn), .parLoad(parLoad), .serIn(serIn),
    .serClk(serClk), .chainEnN(chainEnN), .xferReqN(xferReqN),
    .stackReady(stackReady), .stackWr(stackWr), .stackData(stackData), .fullN(fullN)
  );

  always @(negedge clk) begin
    if (rstN === 1'b1 && stackWr === 1'b1) begin
      wrCount++;
      lastWord = stackData;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic doReset(input bit slave);
    rstN = 1'b0; chainEnN = slave; parLoad = 1'b0; serClk = 1'b0; serIn = 1'b0;
    reqDrv = 1'b1; stackReady = 1'b0; autoMode = 1'b0; parIn = '0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic sendBit(input logic b);
    serIn = b; serClk = 1'b1; step(3);
    serClk = 1'b0; step(3);
  endtask

  task automatic sendWord(input logic [3:0] w);
    for (int i = 0; i < 4; i++) sendBit(w[i]);
  endtask

  task automatic loadWord(input logic [3:0] v);
    parIn = v; parLoad = 1'b1; step(1); parLoad = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;

    // R1 reset state
    doReset(1'b0);
    check(fullN === 1'b1, "R1", "fullN after reset", int'(fullN), 1);
    check(stackWr === 1'b0, "R1", "stackWr after reset", int'(stackWr), 0);

    // R3 serial sweep, first bit lands in bit 0; R4 extra edges while full
    for (int w = 0; w < 16; w++) begin
      sendBit(w[0]); sendBit(w[1]); sendBit(w[2]);
      check(fullN === 1'b1, "R3", "fullN before fourth bit", int'(fullN), 1);
      sendBit(w[3]);
      check(fullN === 1'b0, "R3", "fullN after fourth bit", int'(fullN), 0);
      check(stackData === 4'(w), "R3", "serial word", int'(stackData), w);
      if (w == 9) begin
        sendBit(1'b0); sendBit(1'b1);
        check(stackData === 4'(w), "R4", "word after edges while full", int'(stackData), w);
        check(fullN === 1'b0, "R4", "fullN after edges while full", int'(fullN), 0);
      end
      base = wrCount;
      stackReady = 1'b1; reqDrv = 1'b0;
      step(3);
      reqDrv = 1'b1; stackReady = 1'b0;
      check(wrCount == base + 1, "R5", "serial word writes", wrCount, base + 1);
      check(lastWord === 4'(w), "R5", "written serial word", int'(lastWord), w);
      check(fullN === 1'b1, "R8", "fullN after serial transfer", int'(fullN), 1);
    end

    // R6 stack not ready, then R5/R8 exact timing, R7 long request
    loadWord(4'hA);
    check(fullN === 1'b0 && stackData === 4'hA, "R2", "load 0xA", int'(stackData), 10);
    base = wrCount;
    reqDrv = 1'b0; stackReady = 1'b0;
    step(5);
    check(wrCount == base, "R6", "writes while not ready", wrCount, base);
    check(fullN === 1'b0 && stackData === 4'hA, "R6", "word held while not ready", int'(stackData), 10);
    stackReady = 1'b1;
    #1;
    check(stackWr === 1'b1, "R5", "stackWr when ready", int'(stackWr), 1);
    step(1);
    check(stackWr === 1'b0, "R7", "stackWr second cycle", int'(stackWr), 0);
    check(fullN === 1'b0, "R8", "fullN one cycle after write", int'(fullN), 0);
    step(1);
    check(fullN === 1'b1, "R8", "fullN two cycles after write", int'(fullN), 1);
    step(8);
    check(wrCount == base + 1, "R7", "writes under long request", wrCount, base + 1);
    reqDrv = 1'b1; stackReady = 1'b0;

    // R2 parallel sweep
    for (int v = 0; v < 16; v++) begin
      loadWord(4'(v));
      check(fullN === 1'b0, "R2", "fullN after load", int'(fullN), 0);
      check(stackData === 4'(v), "R2", "loaded word", int'(stackData), v);
      base = wrCount;
      reqDrv = 1'b0; stackReady = 1'b1;
      step(3);
      reqDrv = 1'b1; stackReady = 1'b0;
      check(wrCount == base + 1 && lastWord === 4'(v), "R5", "parallel word written",
            int'(lastWord), v);
    end

    // R9 load held high across the write
    base = wrCount;
    parIn = 4'h6; parLoad = 1'b1; reqDrv = 1'b0; stackReady = 1'b1;
    step(7);
    check(fullN === 1'b0, "R9", "fullN while load held", int'(fullN), 0);
    check(wrCount == base + 1, "R9", "writes while load held", wrCount, base + 1);
    parLoad = 1'b0;
    #1;
    check(fullN === 1'b0, "R9", "fullN as load falls", int'(fullN), 0);
    step(1);
    check(fullN === 1'b1, "R9", "fullN after load low", int'(fullN), 1);
    check(wrCount == base + 1, "R7", "no second write after load", wrCount, base + 1);
    reqDrv = 1'b1; stackReady = 1'b0;

    // R10 slave: chain enable high during reset
    doReset(1'b1);
    sendWord(4'hF);
    check(fullN === 1'b1, "R4", "serial ignored with chain enable high", int'(fullN), 1);
    for (int k = 0; k < 2; k++) begin
      loadWord(4'h3);
      base = wrCount;
      reqDrv = 1'b0; stackReady = 1'b1;
      step(6);
      check(wrCount == base + 1, "R10", "slave write", wrCount, base + 1);
      check(fullN === 1'b0, "R10", "slave waits for chain enable", int'(fullN), 0);
      chainEnN = 1'b0;
      step(1);
      check(fullN === 1'b1, "R10", "slave clears after chain enable", int'(fullN), 1);
      reqDrv = 1'b1; stackReady = 1'b0;
      sendWord(4'h5);
      check(fullN === 1'b0 && stackData === 4'h5, "R3", "serial after slave clear",
            int'(stackData), 5);
      reqDrv = 1'b0; stackReady = 1'b1;
      step(3);
      reqDrv = 1'b1; stackReady = 1'b0;
      chainEnN = 1'b1;
      step(1);
    end

    // R10 master keeps mastership when chain enable later goes high
    doReset(1'b0);
    chainEnN = 1'b1;
    loadWord(4'hC);
    reqDrv = 1'b0; stackReady = 1'b1;
    step(2);
    check(fullN === 1'b1, "R10", "master clears regardless of chain enable", int'(fullN), 1);
    reqDrv = 1'b1; stackReady = 1'b0;

    // R11 automatic entry
    doReset(1'b0);
    autoMode = 1'b1; stackReady = 1'b1;
    base = wrCount;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] w;
      w = 4'((i * 7 + 3) % 16);
      sendWord(w);
      step(2);
      check(lastWord === w, "R11", "auto word", int'(lastWord), int'(w));
      check(wrCount == base + i + 1, "R11", "auto write count", wrCount, base + i + 1);
      check(fullN === 1'b1, "R11", "auto clear", int'(fullN), 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule